// File: doc/BRIEF.md
# Processor execution mode decoder

This block keeps a registered summary of the processor's current execution mode for the instruction decoder. It classifies the machine into a top-level mode (Legacy or Long) and a finer submode (Real, Protected, Virtual-8086, Compatibility, 64-bit). From that classification and the segment attributes it derives the default and alternate operand widths, the default and alternate address widths, and the stack width. It also passes on the current privilege level and the paging and protection enables.

The summary changes only when a triggering register write is signalled. There are four triggers: a write to the paging/protection control register, a write to the code-segment attributes, a write to the stack-segment attributes, and a refresh request aimed at the summary itself. On a write trigger, the value being written replaces the matching current input when the summary is computed. The registers that hold the source values are kept outside this block. Every update is marked by a one-cycle valid pulse. The new summary appears on the outputs on the clock edge that samples the trigger.

Top module: `mode_decoder`

## Requirements
- R1: When the long-mode-active input is 1, the mode output is Long (1). The submode is 64-bit (code 4) if the effective code-segment long bit is 1, and Compatibility (code 3) otherwise.
- R2: When long-mode-active is 0, the mode output is Legacy (0). The submode is Real (code 0) if the effective protection enable is 0, Virtual-8086 (code 2) if protection is 1 and the VM flag is 1, and Protected (code 1) otherwise.
- R3: The privilege output equals the effective code-segment privilege field. The paging and protection outputs equal the effective paging and protection enables.
- R4: Size codes are 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. If the submode is 64-bit or the effective code-segment default-size bit is 1, the default operand code is 2 and the alternate is 1. Otherwise the default is 1 and the alternate is 2.
- R5: In the 64-bit submode the default address code is 3 and the alternate is 2. In any other submode with the code-segment default-size bit at 1, the default is 2 and the alternate is 1. Otherwise the default is 1 and the alternate is 2.
- R6: The stack code is 3 in the 64-bit submode. In any other submode it is 2 if the effective stack-segment default-size bit is 1, and 1 otherwise.
- R7: A refresh request recomputes the summary from the current-value inputs alone. It carries no data.
- R8: A write trigger for the control register, the code-segment attributes or the stack-segment attributes makes the written fields override the matching current inputs. Several triggers in one cycle combine.
- R9: Without a trigger, the summary outputs hold their values, even while the current-value inputs change.
- R10: Reset (rst_n low at a clock edge) clears every summary output and the valid pulse to 0.
- R11: The valid output is 1 for exactly one cycle per triggered cycle, in the cycle after the edge that sampled the trigger. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_lma | input | 1 | Long-mode-active flag |
| cur_pg | input | 1 | Current paging enable |
| cur_pe | input | 1 | Current protection enable |
| cur_cs_l | input | 1 | Current code-segment long bit |
| cur_cs_db | input | 1 | Current code-segment default-size bit |
| cur_cs_dpl | input | 2 | Current code-segment privilege field |
| cur_ss_db | input | 1 | Current stack-segment default-size bit |
| cur_vm | input | 1 | Virtual-8086 flag |
| refresh | input | 1 | Recompute trigger for the summary itself |
| wr_ctrl | input | 1 | Control-register write trigger |
| wr_ctrl_pg | input | 1 | Paging enable being written |
| wr_ctrl_pe | input | 1 | Protection enable being written |
| wr_cs | input | 1 | Code-segment attribute write trigger |
| wr_cs_l | input | 1 | Long bit being written |
| wr_cs_db | input | 1 | Default-size bit being written |
| wr_cs_dpl | input | 2 | Privilege field being written |
| wr_ss | input | 1 | Stack-segment attribute write trigger |
| wr_ss_db | input | 1 | Stack default-size bit being written |
| dec_valid | output | 1 | One-cycle update pulse |
| dec_mode | output | 1 | 0 Legacy, 1 Long |
| dec_submode | output | 3 | Submode code |
| dec_cpl | output | 2 | Current privilege level |
| dec_paging | output | 1 | Paging enable |
| dec_prot | output | 1 | Protection enable |
| dec_def_op | output | 2 | Default operand size code |
| dec_alt_op | output | 2 | Alternate operand size code |
| dec_def_addr | output | 2 | Default address size code |
| dec_alt_addr | output | 2 | Alternate address size code |
| dec_stack | output | 2 | Stack size code |

## Verification
The hardest case to reach is a write trigger whose data disagrees with the current-value inputs. The bench sets up these conflicts on purpose. It drives a protection-enable write while the current enable is clear, and a code-segment write with the long bit set while the current long bit is clear. It also fires triggers on consecutive cycles and in combination, so that each override and each one-cycle valid pulse can be seen on its own. The hold rule is tested by changing every current input with no trigger for several cycles and comparing the outputs against the last expected summary.

// File: rtl/mode_dec_pkg.sv
// Package: shared types and size codes for the execution mode decoder.
// Assumes a two-bit privilege field and two-bit size codes.
package mode_dec_pkg;

    localparam int DPL_W = 2;
    localparam int SZ_W  = 2;

    localparam logic [SZ_W-1:0] SZ_16 = 2'd1;
    localparam logic [SZ_W-1:0] SZ_32 = 2'd2;
    localparam logic [SZ_W-1:0] SZ_64 = 2'd3;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_LONG   = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    typedef struct packed {
        logic             lma;
        logic             pg;
        logic             pe;
        logic             cs_l;
        logic             cs_db;
        logic [DPL_W-1:0] cs_dpl;
        logic             ss_db;
        logic             vm;
    } mode_src_t;

    typedef struct packed {
        logic [SZ_W-1:0] def_op;
        logic [SZ_W-1:0] alt_op;
        logic [SZ_W-1:0] def_addr;
        logic [SZ_W-1:0] alt_addr;
        logic [SZ_W-1:0] stk;
    } size_set_t;

    typedef struct packed {
        mode_e            mode;
        submode_e         sub;
        logic [DPL_W-1:0] cpl;
        logic             pg;
        logic             pe;
        size_set_t        sz;
    } mode_sum_t;

endpackage

// File: rtl/mode_src_merge.sv
// Module: forms the effective source fields. Each pending write trigger
// replaces the matching current-value fields with the data being written.
// Assumes the triggers are independent and may be asserted together.
module mode_src_merge
    import mode_dec_pkg::*;
(
    input  mode_src_t        cur,
    input  logic             wr_ctrl,
    input  logic             wr_ctrl_pg,
    input  logic             wr_ctrl_pe,
    input  logic             wr_cs,
    input  logic             wr_cs_l,
    input  logic             wr_cs_db,
    input  logic [DPL_W-1:0] wr_cs_dpl,
    input  logic             wr_ss,
    input  logic             wr_ss_db,
    output mode_src_t        eff
);

    // Override each field group that has a write in flight.
    always_comb begin
        eff = cur;
        if (wr_ctrl) begin
            eff.pg = wr_ctrl_pg;
            eff.pe = wr_ctrl_pe;
        end
        if (wr_cs) begin
            eff.cs_l   = wr_cs_l;
            eff.cs_db  = wr_cs_db;
            eff.cs_dpl = wr_cs_dpl;
        end
        if (wr_ss) begin
            eff.ss_db = wr_ss_db;
        end
    end

endmodule

// File: rtl/mode_classify.sv
// Module: classifies the effective sources into a mode and a submode.
// Assumes long-mode-active takes priority over the protection state.
module mode_classify
    import mode_dec_pkg::*;
(
    input  mode_src_t src,
    output mode_e     mode,
    output submode_e  sub
);

    // Walk the mode hierarchy: long or legacy first, then the submode.
    always_comb begin
        if (src.lma) begin
            mode = MODE_LONG;
            sub  = src.cs_l ? SUB_64 : SUB_COMPAT;
        end else begin
            mode = MODE_LEGACY;
            if (!src.pe)
                sub = SUB_REAL;
            else if (src.vm)
                sub = SUB_V86;
            else
                sub = SUB_PROT;
        end
    end

endmodule

// File: rtl/mode_size_derive.sv
// Module: derives the operand, address and stack size codes from the
// submode and the segment default-size bits. Purely combinational.
module mode_size_derive
    import mode_dec_pkg::*;
(
    input  submode_e  sub,
    input  logic      cs_db,
    input  logic      ss_db,
    output size_set_t sz
);

    logic is64;

    // Flag the 64-bit submode, which outranks every segment bit.
    always_comb is64 = (sub == SUB_64);

    // Operand sizes: the 32-bit default applies in 64-bit or wide code.
    always_comb begin
        if (is64 || cs_db) begin
            sz.def_op = SZ_32;
            sz.alt_op = SZ_16;
        end else begin
            sz.def_op = SZ_16;
            sz.alt_op = SZ_32;
        end
    end

    // Address sizes: three layers, 64-bit then wide code then narrow.
    always_comb begin
        if (is64) begin
            sz.def_addr = SZ_64;
            sz.alt_addr = SZ_32;
        end else if (cs_db) begin
            sz.def_addr = SZ_32;
            sz.alt_addr = SZ_16;
        end else begin
            sz.def_addr = SZ_16;
            sz.alt_addr = SZ_32;
        end
    end

    // Stack size: 64-bit submode, else the stack segment's own bit.
    always_comb begin
        if (is64)
            sz.stk = SZ_64;
        else if (ss_db)
            sz.stk = SZ_32;
        else
            sz.stk = SZ_16;
    end

endmodule

// File: rtl/mode_decoder.sv
// Module: top of the execution mode decoder. Merges pending writes into the
// current source values, classifies the mode, derives the sizes, and
// latches the summary with a one-cycle valid pulse on any trigger.
// Assumes the source registers live outside; reset is synchronous, active low.
module mode_decoder
    import mode_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_lma,
    input  logic             cur_pg,
    input  logic             cur_pe,
    input  logic             cur_cs_l,
    input  logic             cur_cs_db,
    input  logic [DPL_W-1:0] cur_cs_dpl,
    input  logic             cur_ss_db,
    input  logic             cur_vm,
    input  logic             refresh,
    input  logic             wr_ctrl,
    input  logic             wr_ctrl_pg,
    input  logic             wr_ctrl_pe,
    input  logic             wr_cs,
    input  logic             wr_cs_l,
    input  logic             wr_cs_db,
    input  logic [DPL_W-1:0] wr_cs_dpl,
    input  logic             wr_ss,
    input  logic             wr_ss_db,
    output logic             dec_valid,
    output logic             dec_mode,
    output logic [2:0]       dec_submode,
    output logic [DPL_W-1:0] dec_cpl,
    output logic             dec_paging,
    output logic             dec_prot,
    output logic [SZ_W-1:0]  dec_def_op,
    output logic [SZ_W-1:0]  dec_alt_op,
    output logic [SZ_W-1:0]  dec_def_addr,
    output logic [SZ_W-1:0]  dec_alt_addr,
    output logic [SZ_W-1:0]  dec_stack
);

    mode_src_t cur_src, eff_src;
    mode_e     nxt_mode;
    submode_e  nxt_sub;
    size_set_t nxt_sz;
    mode_sum_t nxt_sum, sum_q;
    logic      trig, valid_q;

    // Gather the current-value inputs into one record.
    always_comb cur_src = '{lma: cur_lma, pg: cur_pg, pe: cur_pe,
                            cs_l: cur_cs_l, cs_db: cur_cs_db,
                            cs_dpl: cur_cs_dpl, ss_db: cur_ss_db,
                            vm: cur_vm};

    // Any of the four triggers asks for a recompute.
    always_comb trig = refresh | wr_ctrl | wr_cs | wr_ss;

    mode_src_merge u_merge (
        .cur        (cur_src),
        .wr_ctrl    (wr_ctrl),
        .wr_ctrl_pg (wr_ctrl_pg),
        .wr_ctrl_pe (wr_ctrl_pe),
        .wr_cs      (wr_cs),
        .wr_cs_l    (wr_cs_l),
        .wr_cs_db   (wr_cs_db),
        .wr_cs_dpl  (wr_cs_dpl),
        .wr_ss      (wr_ss),
        .wr_ss_db   (wr_ss_db),
        .eff        (eff_src)
    );

    mode_classify u_classify (
        .src  (eff_src),
        .mode (nxt_mode),
        .sub  (nxt_sub)
    );

    mode_size_derive u_sizes (
        .sub   (nxt_sub),
        .cs_db (eff_src.cs_db),
        .ss_db (eff_src.ss_db),
        .sz    (nxt_sz)
    );

    // Assemble the next summary record.
    always_comb nxt_sum = '{mode: nxt_mode, sub: nxt_sub,
                            cpl: eff_src.cs_dpl, pg: eff_src.pg,
                            pe: eff_src.pe, sz: nxt_sz};

    // Latch the summary on a trigger; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (trig)
            sum_q <= nxt_sum;
    end

    // Raise the update pulse for the cycle after each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= trig;
    end

    // Drive the decoder-facing outputs from the latched record.
    always_comb begin
        dec_valid    = valid_q;
        dec_mode     = sum_q.mode;
        dec_submode  = sum_q.sub;
        dec_cpl      = sum_q.cpl;
        dec_paging   = sum_q.pg;
        dec_prot     = sum_q.pe;
        dec_def_op   = sum_q.sz.def_op;
        dec_alt_op   = sum_q.sz.alt_op;
        dec_def_addr = sum_q.sz.def_addr;
        dec_alt_addr = sum_q.sz.alt_addr;
        dec_stack    = sum_q.sz.stk;
    end

    // R1: long-mode-active with a set long bit and no code-segment write gives 64-bit.
    a_r1_long64: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && cur_lma && !wr_cs && cur_cs_l) |=>
            (dec_mode == 1'b1 && dec_submode == 3'd4));

    // R2: legacy with protection off and no control write gives Real.
    a_r2_real: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cur_lma && !wr_ctrl && !cur_pe) |=>
            (dec_mode == 1'b0 && dec_submode == 3'd0));

    // R3: a code-segment write sets the privilege output from its data.
    a_r3_cpl_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cs |=> (dec_cpl == $past(wr_cs_dpl)));

    // R6: the 64-bit submode always comes with 64-bit stack and address.
    a_r6_sixty_four_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_submode == 3'd4) |->
            (dec_stack == 2'd3 && dec_def_addr == 2'd3 && dec_def_op == 2'd2));

    // R9: no trigger keeps the summary stable.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> ($stable(dec_submode) && $stable(dec_cpl) &&
                   $stable(dec_stack) && $stable(dec_paging)));

    // R11: the valid pulse follows a trigger.
    a_r11_valid_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> dec_valid);

    // R11: no pulse without a trigger.
    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !dec_valid);

endmodule

// File: tb/mode_decoder_bench.sv
// Bench: scoreboard for the execution mode decoder. A driver task pushes the
// expected summary for each trigger; a monitor pops on each valid pulse.
module mode_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_lma = 0, cur_pg = 0, cur_pe = 0, cur_cs_l = 0, cur_cs_db = 0;
    logic [1:0] cur_cs_dpl = 0;
    logic cur_ss_db = 0, cur_vm = 0;
    logic refresh = 0, wr_ctrl = 0, wr_ctrl_pg = 0, wr_ctrl_pe = 0;
    logic wr_cs = 0, wr_cs_l = 0, wr_cs_db = 0;
    logic [1:0] wr_cs_dpl = 0;
    logic wr_ss = 0, wr_ss_db = 0;
    logic dec_valid, dec_mode, dec_paging, dec_prot;
    logic [2:0] dec_submode;
    logic [1:0] dec_cpl, dec_def_op, dec_alt_op, dec_def_addr, dec_alt_addr, dec_stack;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [17:0] exp_q[$];
    logic [17:0] last_exp = '0;

    always #5 clk = ~clk;

    mode_decoder u_mode_decoder (
        .clk, .rst_n, .cur_lma, .cur_pg, .cur_pe, .cur_cs_l, .cur_cs_db,
        .cur_cs_dpl, .cur_ss_db, .cur_vm, .refresh, .wr_ctrl, .wr_ctrl_pg,
        .wr_ctrl_pe, .wr_cs, .wr_cs_l, .wr_cs_db, .wr_cs_dpl, .wr_ss,
        .wr_ss_db, .dec_valid, .dec_mode, .dec_submode, .dec_cpl, .dec_paging,
        .dec_prot, .dec_def_op, .dec_alt_op, .dec_def_addr, .dec_alt_addr,
        .dec_stack
    );

    function automatic logic [17:0] observed();
        return {dec_mode, dec_submode, dec_cpl, dec_paging, dec_prot,
                dec_def_op, dec_alt_op, dec_def_addr, dec_alt_addr, dec_stack};
    endfunction

    // Reference summary built from R1..R6 and the size codes of R4.
    function automatic logic [17:0] model(input logic lma, pg, pe, l, db,
                                          input logic [1:0] dpl,
                                          input logic sdb, vm);
        logic [2:0] sub;
        logic [1:0] dop, aop, dad, aad, stk;
        if (lma) sub = l ? 3'd4 : 3'd3;
        else if (!pe) sub = 3'd0;
        else sub = vm ? 3'd2 : 3'd1;
        if (sub == 3'd4 || db) begin dop = 2; aop = 1; end
        else begin dop = 1; aop = 2; end
        if (sub == 3'd4) begin dad = 3; aad = 2; end
        else if (db) begin dad = 2; aad = 1; end
        else begin dad = 1; aad = 2; end
        stk = (sub == 3'd4) ? 2'd3 : (sdb ? 2'd2 : 2'd1);
        return {lma, sub, dpl, pg, pe, dop, aop, dad, aad, stk};
    endfunction

    task automatic check(input string req, input logic [17:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: sets the triggers at a falling edge and queues the expectation.
    task automatic drive(input string tag, input logic rf, wc, cpg, cpe,
                         input logic wcs, l, db, input logic [1:0] dpl,
                         input logic wss, sdb);
        logic epg, epe, el, edb, esdb;
        logic [1:0] edpl;
        @(negedge clk);
        refresh = rf; wr_ctrl = wc; wr_ctrl_pg = cpg; wr_ctrl_pe = cpe;
        wr_cs = wcs; wr_cs_l = l; wr_cs_db = db; wr_cs_dpl = dpl;
        wr_ss = wss; wr_ss_db = sdb;
        epg = wc ? cpg : cur_pg;   epe = wc ? cpe : cur_pe;
        el = wcs ? l : cur_cs_l;   edb = wcs ? db : cur_cs_db;
        edpl = wcs ? dpl : cur_cs_dpl;
        esdb = wss ? sdb : cur_ss_db;
        exp_q.push_back(model(cur_lma, epg, epe, el, edb, edpl, esdb, cur_vm));
        $display("drive %s", tag);
    endtask

    task automatic idle();
        @(negedge clk);
        refresh = 0; wr_ctrl = 0; wr_cs = 0; wr_ss = 0;
    endtask

    // Monitor: each valid pulse pops one expected summary (R11 if none).
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual valid=1 expected valid=0");
            end else begin
                last_exp = exp_q.pop_front();
                check("R1-R8 scoreboard", observed(), last_exp);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears everything.
        check("R10", {observed(), dec_valid}, 19'd0);
        rst_n = 1;

        // R7, R2: refresh with all-zero current inputs gives Real, 16-bit.
        drive("R7 real", 1,0,0,0, 0,0,0,2'd0, 0,0); idle();
        // R8, R2: control write enables protection over a clear current value.
        drive("R8 prot", 0,1,0,1, 0,0,0,2'd0, 0,0); idle();
        // R2: Virtual-8086 from current inputs.
        cur_pe = 1; cur_vm = 1;
        drive("R2 v86", 1,0,0,0, 0,0,0,2'd0, 0,0); idle();
        // R1, R4, R5, R6, R3: code-segment write sets long bit, privilege 3.
        cur_vm = 0; cur_lma = 1;
        drive("R1 64", 0,0,0,0, 1,1,0,2'd3, 0,0); idle();
        // R1, R6: compatibility with wide code and a stack write.
        cur_cs_db = 1;
        drive("R1 compat", 0,0,0,0, 0,0,0,2'd0, 1,1); idle();
        // R4, R5, R6: legacy protected, wide code, narrow stack.
        cur_lma = 0; cur_ss_db = 0;
        drive("R5 prot32", 1,0,0,0, 0,0,0,2'd0, 0,0); idle();
        // R3: paging enable through a control write.
        drive("R3 paging", 0,1,1,1, 0,0,0,2'd1, 0,0); idle();
        // R11, R8: back-to-back and combined triggers.
        drive("R11 b2b a", 0,0,0,0, 1,0,0,2'd2, 0,0);
        drive("R11 b2b b", 0,1,1,0, 1,0,1,2'd1, 1,1);
        idle();
        // R7: refresh with current long bit set but not active long mode.
        cur_cs_l = 1; cur_cs_dpl = 2'd3;
        drive("R7 ignore l", 1,0,0,0, 0,0,0,2'd0, 0,0); idle();
        repeat (2) @(negedge clk);

        // R9: change every current input with no trigger; outputs hold.
        cur_lma = 1; cur_pg = 1; cur_pe = 0; cur_cs_db = 0; cur_ss_db = 1;
        cur_vm = 1; cur_cs_dpl = 2'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9", {observed(), dec_valid}, {last_exp, 1'b0});
        end
        // R1: the held change takes effect on the next refresh.
        drive("R1 refresh", 1,0,0,0, 0,0,0,2'd0, 0,0); idle();
        repeat (3) @(negedge clk);
        // R11: every queued expectation got its pulse.
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule